// File: doc/BRIEF.md
# Heterogeneous Four-Unit Processing Group

This block is a single processing group of a loop accelerator. It holds four functional units, each with a private 16-entry by 32-bit register file (two read ports, one write port). Every unit executes single-cycle integer ALU operations. Only unit 1 can issue memory loads and stores, and only unit 2 has a pipelined multiplier, so the two costly resources are shared by the whole group rather than copied into every lane.

Operands reach each unit through a statically configured selector per operand: eight selectors in all, two per unit. Each selector picks one of four sources:
- the unit's own register file;
- any of the four registered unit results (a direct forwarding path that writes no register);
- the matching unit of the neighbouring group on the left or on the right;
- zero.

The selections come from a loop configuration word that is captured once per loop. Nothing in the group arbitrates routes at run time.

A scheduler that runs several logical lanes on the one multiplier staggers their multiplies by one cycle each. The pipelined multiplier accepts one request per cycle, so staggered lanes never contend for it. An opcode that needs a resource the unit lacks raises a flag for that unit, and its result is dropped.

Top module: `pe_group`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_out` is 0 and `res_valid`, `illegal_op` and `mem_req` are all low.
- R2: The ALU opcodes are 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 shift left, 7 logical shift right, 8 signed less-than (result 1 or 0), and 9 move A. The shift amount is operand B bits [4:0]. An ALU op issued in cycle t shows on `res_out` with `res_valid` high after edge t. Between results, `res_out` holds its last value and `res_valid` is low.
- R3: For unit k, operand A uses configuration bits [6k+2:6k] and operand B uses bits [6k+5:6k+3]. Selector code 0 reads the unit's register file (A at `iss_ra`, B at `iss_rb`). Codes 1 to 4 take the current `res_out` of unit 0 to 3. Code 7 gives zero.
- R4: Selector code 5 takes lane k of `left_in` and code 6 takes lane k of `right_in`. Lane k of `res_out` is the value a neighbouring group receives for its unit k.
- R5: `cfg_word` is captured only at an edge where `cfg_load` is high. The captured word governs operations issued from the next cycle on. Changes of `cfg_word` while `cfg_load` is low have no effect.
- R6: Opcode 10 on unit 2 multiplies A by B and keeps the low 32 bits. It completes two edges after issue, and the multiplier accepts one operation every cycle.
- R7: On unit 1, opcode 11 loads and opcode 12 stores. A request issued in cycle t drives `mem_req`, `mem_wr` (high for a store), `mem_addr` (operand A) and `mem_wdata` (operand B) after edge t. For a load, `mem_rdata` is sampled at edge t+1 and becomes the unit's result at that edge. A store produces no result.
- R8: Opcode 10 on any unit other than 2, or opcode 11 or 12 on any unit other than 1, sets that unit's `illegal_op` for one cycle. It produces no result, no register write and no memory request.
- R9: When a multiply or load completes on the same edge where a new ALU op on that unit would complete, the long result takes the output and the write port. The ALU op is discarded.
- R10: A result is written to register `iss_rd` of its own unit only if `iss_we` was high when the op issued. The write is visible to reads in the following cycle.
- R11: Opcodes 0, 13, 14 and 15 produce no result, no write and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture the loop configuration word |
| cfg_word | input | 24 | Eight 3-bit operand selectors |
| iss_valid | input | 4 | Per-unit issue strobe |
| iss_op | input | 16 | Per-unit 4-bit opcode |
| iss_rd | input | 16 | Per-unit destination register |
| iss_ra | input | 16 | Per-unit register-file read address A |
| iss_rb | input | 16 | Per-unit register-file read address B |
| iss_we | input | 4 | Per-unit write-back enable |
| left_in | input | 128 | Results of the left neighbour group, one lane per unit |
| right_in | input | 128 | Results of the right neighbour group, one lane per unit |
| res_out | output | 128 | Registered unit results |
| res_valid | output | 4 | A new result was produced at the last edge |
| illegal_op | output | 4 | Unsupported opcode flag per unit |
| mem_req | output | 1 | Memory request from unit 1 |
| mem_wr | output | 1 | Request is a store |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid the cycle after the request |

## Verification
On unit 2, the completion of a multiply can fall on the same edge as a newly issued ALU op; on unit 1, a returning load can collide the same way. The bench provokes this by issuing an ALU op with write enable exactly one cycle after the long op, both in a directed sequence and through random opcode mixes. It judges the outcome from the output value at that edge and from a later read of the ALU op's destination register through the unit's own result path. A reference model in the bench predicts every output on every clock, and it also tracks configuration words that change without a load strobe.

// File: rtl/pe_group_pkg.sv
package pe_group_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_SLT = 4'd8,
    OP_MOV = 4'd9,
    OP_MUL = 4'd10,
    OP_LD  = 4'd11,
    OP_ST  = 4'd12
  } pe_op_e;

  // operand source codes: 0 = own register file, 1..N = group result,
  // N+1 = left neighbour, N+2 = right neighbour, anything else = zero
  localparam int SRC_RF = 0;
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pe_opnd_mux.sv
module pe_opnd_mux #(
  parameter int DW = 32,
  parameter int N  = 4,
  parameter int SW = $clog2(N + 4)
) (
  input  logic [SW-1:0]   sel,
  input  logic [DW-1:0]   rf_val,
  input  logic [N*DW-1:0] grp_val,
  input  logic [DW-1:0]   left_val,
  input  logic [DW-1:0]   right_val,
  output logic [DW-1:0]   y
);
  always_comb begin
    y = '0;
    if (sel == SW'(pe_group_pkg::SRC_RF)) y = rf_val;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i + 1)) y = grp_val[i*DW +: DW];
    end
    if (sel == SW'(N + 1)) y = left_val;
    if (sel == SW'(N + 2)) y = right_val;
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import pe_group_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y,
  output logic            is_alu
);
  localparam int SHW = $clog2(DW);

  always_comb begin
    y      = '0;
    is_alu = 1'b1;
    case (op)
      OP_ADD: y = a + b;
      OP_SUB: y = a - b;
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_XOR: y = a ^ b;
      OP_SHL: y = a << b[SHW-1:0];
      OP_SHR: y = a >> b[SHW-1:0];
      OP_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
      OP_MOV: y = a;
      default: is_alu = 1'b0;
    endcase
  end
endmodule

// File: rtl/pe_fu.sv
module pe_fu
  import pe_group_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RF_DEPTH = 16,
  parameter int AW       = $clog2(RF_DEPTH),
  parameter int N        = 4,
  parameter int SW       = $clog2(N + 4),
  parameter bit HAS_MUL  = 1'b0,
  parameter bit HAS_MEM  = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iv,
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   rd,
  input  logic [AW-1:0]   ra,
  input  logic [AW-1:0]   rb,
  input  logic            we,
  input  logic [SW-1:0]   sel_a,
  input  logic [SW-1:0]   sel_b,
  input  logic [N*DW-1:0] grp_out,
  input  logic [DW-1:0]   left_in,
  input  logic [DW-1:0]   right_in,
  output logic [DW-1:0]   res_out,
  output logic            res_valid,
  output logic            illegal,
  output logic            mem_req,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  logic [DW-1:0] rf_a, rf_b, opa, opb, alu_y, long_res, wb_data;
  logic [AW-1:0] wb_addr;
  logic          alu_ok, wb_en, is_mul, is_ld, is_st, bad, start_long;

  // long-latency pipeline stage (multiply or load in flight)
  logic          lp_v, lp_ld, lp_we;
  logic [AW-1:0] lp_rd;
  logic [DW-1:0] lp_prod;

  pe_regfile #(.DW(DW), .DEPTH(RF_DEPTH), .AW(AW)) u_rf (
    .clk(clk), .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
    .raddr_a(ra), .raddr_b(rb), .rdata_a(rf_a), .rdata_b(rf_b)
  );

  pe_opnd_mux #(.DW(DW), .N(N), .SW(SW)) u_mux_a (
    .sel(sel_a), .rf_val(rf_a), .grp_val(grp_out),
    .left_val(left_in), .right_val(right_in), .y(opa)
  );

  pe_opnd_mux #(.DW(DW), .N(N), .SW(SW)) u_mux_b (
    .sel(sel_b), .rf_val(rf_b), .grp_val(grp_out),
    .left_val(left_in), .right_val(right_in), .y(opb)
  );

  pe_alu #(.DW(DW)) u_alu (
    .op(op), .a(opa), .b(opb), .y(alu_y), .is_alu(alu_ok)
  );

  assign is_mul     = (op == OP_MUL);
  assign is_ld      = (op == OP_LD);
  assign is_st      = (op == OP_ST);
  assign bad        = iv && ((is_mul && !HAS_MUL) || ((is_ld || is_st) && !HAS_MEM));
  assign start_long = iv && ((is_mul && HAS_MUL) || (is_ld && HAS_MEM));
  assign long_res   = lp_ld ? mem_rdata : lp_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_v  <= 1'b0;
      lp_ld <= 1'b0;
      lp_we <= 1'b0;
      lp_rd <= '0;
    end else begin
      lp_v  <= start_long;
      lp_ld <= is_ld;
      lp_we <= we;
      lp_rd <= rd;
    end
  end

  generate
    if (HAS_MUL) begin : g_mul
      always_ff @(posedge clk) begin
        if (rst) lp_prod <= '0;
        else     lp_prod <= opa * opb;
      end
    end else begin : g_no_mul
      assign lp_prod = '0;
    end

    if (HAS_MEM) begin : g_mem
      always_ff @(posedge clk) begin
        if (rst) begin
          mem_req   <= 1'b0;
          mem_wr    <= 1'b0;
          mem_addr  <= '0;
          mem_wdata <= '0;
        end else begin
          mem_req   <= iv && (is_ld || is_st);
          mem_wr    <= iv && is_st;
          mem_addr  <= opa;
          mem_wdata <= opb;
        end
      end
    end else begin : g_no_mem
      assign mem_req   = 1'b0;
      assign mem_wr    = 1'b0;
      assign mem_addr  = '0;
      assign mem_wdata = '0;
    end
  endgenerate

  // write port: a completing long op wins over a new ALU op
  always_comb begin
    if (lp_v) begin
      wb_en   = lp_we;
      wb_addr = lp_rd;
      wb_data = long_res;
    end else begin
      wb_en   = iv && alu_ok && we;
      wb_addr = rd;
      wb_data = alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      res_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      illegal <= bad;
      if (lp_v) begin
        res_out   <= long_res;
        res_valid <= 1'b1;
      end else if (iv && alu_ok) begin
        res_out   <= alu_y;
        res_valid <= 1'b1;
      end else begin
        res_valid <= 1'b0;
      end
    end
  end

  // R2: an uncontended ALU op produces a result on the next edge
  assert_alu_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (iv && alu_ok && !lp_v) |=> res_valid);

  // R8: an unsupported op with no long op completing leaves no result
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (bad && !lp_v) |=> (illegal && !res_valid));

  generate
    if (HAS_MUL) begin : g_mul_chk
      assert_mul_two_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (iv && is_mul) |-> ##2 res_valid);
    end else begin : g_nomul_chk
      assert_mul_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (iv && is_mul) |=> illegal);
    end
    if (HAS_MEM) begin : g_mem_chk
      assert_mem_req_source_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $past(iv && (is_ld || is_st)));
    end
  endgenerate
endmodule

// File: rtl/pe_group.sv
module pe_group
  import pe_group_pkg::*;
#(
  parameter int DW       = 32,
  parameter int N        = 4,
  parameter int RF_DEPTH = 16,
  parameter int MUL_UNIT = 2,
  parameter int MEM_UNIT = 1,
  parameter int AW       = $clog2(RF_DEPTH),
  parameter int SW       = $clog2(N + 4),
  parameter int CW       = 2 * N * SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CW-1:0]     cfg_word,
  input  logic [N-1:0]      iss_valid,
  input  logic [N*OP_W-1:0] iss_op,
  input  logic [N*AW-1:0]   iss_rd,
  input  logic [N*AW-1:0]   iss_ra,
  input  logic [N*AW-1:0]   iss_rb,
  input  logic [N-1:0]      iss_we,
  input  logic [N*DW-1:0]   left_in,
  input  logic [N*DW-1:0]   right_in,
  output logic [N*DW-1:0]   res_out,
  output logic [N-1:0]      res_valid,
  output logic [N-1:0]      illegal_op,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  logic [CW-1:0]   cfg_q;
  logic [N-1:0]    req_all, wr_all;
  logic [DW-1:0]   addr_all  [N];
  logic [DW-1:0]   wdata_all [N];

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_word;
  end

  generate
    for (genvar k = 0; k < N; k++) begin : g_fu
      pe_fu #(
        .DW(DW), .RF_DEPTH(RF_DEPTH), .AW(AW), .N(N), .SW(SW),
        .HAS_MUL(k == MUL_UNIT), .HAS_MEM(k == MEM_UNIT)
      ) u_fu (
        .clk(clk), .rst(rst),
        .iv(iss_valid[k]),
        .op(iss_op[k*OP_W +: OP_W]),
        .rd(iss_rd[k*AW +: AW]),
        .ra(iss_ra[k*AW +: AW]),
        .rb(iss_rb[k*AW +: AW]),
        .we(iss_we[k]),
        .sel_a(cfg_q[(2*k)*SW +: SW]),
        .sel_b(cfg_q[(2*k+1)*SW +: SW]),
        .grp_out(res_out),
        .left_in(left_in[k*DW +: DW]),
        .right_in(right_in[k*DW +: DW]),
        .res_out(res_out[k*DW +: DW]),
        .res_valid(res_valid[k]),
        .illegal(illegal_op[k]),
        .mem_req(req_all[k]),
        .mem_wr(wr_all[k]),
        .mem_addr(addr_all[k]),
        .mem_wdata(wdata_all[k]),
        .mem_rdata(mem_rdata)
      );
    end
  endgenerate

  // only the memory-capable unit drives non-zero request fields
  always_comb begin
    mem_req   = |req_all;
    mem_wr    = |wr_all;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int k = 0; k < N; k++) begin
      mem_addr  = mem_addr  | addr_all[k];
      mem_wdata = mem_wdata | wdata_all[k];
    end
  end

  // R5: the held configuration follows the word presented with the load strobe
  assert_cfg_capture_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (cfg_q == $past(cfg_word)));

  // R7: the memory request comes from at most one unit
  assert_single_requester_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(req_all) <= 1);
endmodule

// File: tb/sim_pe_group.sv
module sim_pe_group;
  localparam int N = 4, DW = 32, AW = 4, SW = 3, CW = 2 * N * SW;

  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic            cfg_load;
  logic [CW-1:0]   cfg_word;
  logic [N-1:0]    iss_valid, iss_we, res_valid, illegal_op;
  logic [N*4-1:0]  iss_op, iss_rd, iss_ra, iss_rb;
  logic [N*DW-1:0] left_in, right_in, res_out;
  logic            mem_req, mem_wr;
  logic [DW-1:0]   mem_addr, mem_wdata, mem_rdata;

  pe_group u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_rd(iss_rd), .iss_ra(iss_ra),
    .iss_rb(iss_rb), .iss_we(iss_we), .left_in(left_in), .right_in(right_in),
    .res_out(res_out), .res_valid(res_valid), .illegal_op(illegal_op),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  string tag = "R1";

  // stimulus
  bit            s_v[N], s_we[N], s_cl;
  int            s_op[N], s_rd[N], s_ra[N], s_rb[N];
  logic [DW-1:0] s_l[N], s_r[N];
  logic [CW-1:0] s_cw;

  // reference model state
  logic [DW-1:0] m_rf[N][16];
  logic [DW-1:0] m_out[N], lp_prod[N];
  bit            m_val[N], m_ill[N], lp_v[N], lp_ld[N], lp_we[N];
  int            lp_rd[N];
  bit            m_req, m_wr;
  logic [DW-1:0] m_addr, m_wdata;
  logic [CW-1:0] m_cfg;
  logic [DW-1:0] mem[64];

  task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    for (int k = 0; k < N; k++) begin
      s_v[k] = 0; s_we[k] = 0; s_op[k] = 0;
      s_rd[k] = 0; s_ra[k] = 0; s_rb[k] = 0;
      s_l[k] = $urandom; s_r[k] = $urandom;
    end
    s_cl = 0;
    s_cw = CW'($urandom);
  endtask

  function automatic logic [CW-1:0] cfg_all(int a, int b);
    logic [CW-1:0] w = '0;
    for (int k = 0; k < N; k++) begin
      w[(2*k)*SW +: SW]   = SW'(a);
      w[(2*k+1)*SW +: SW] = SW'(b);
    end
    return w;
  endfunction

  function automatic logic [DW-1:0] pick(int k, int sel, logic [DW-1:0] rfv);
    if (sel == 0) return rfv;
    if (sel >= 1 && sel <= N) return m_out[sel-1];
    if (sel == N + 1) return s_l[k];
    if (sel == N + 2) return s_r[k];
    return '0;
  endfunction

  function automatic logic [DW-1:0] ref_alu(int op, logic [DW-1:0] a, logic [DW-1:0] b, output bit ok);
    ok = 1;
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a << b[4:0];
      7: return a >> b[4:0];
      8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      9: return a;
      default: begin ok = 0; return '0; end
    endcase
  endfunction

  task automatic apply();
    for (int k = 0; k < N; k++) begin
      iss_valid[k]          = s_v[k];
      iss_we[k]             = s_we[k];
      iss_op[k*4 +: 4]      = s_op[k][3:0];
      iss_rd[k*4 +: 4]      = s_rd[k][3:0];
      iss_ra[k*4 +: 4]      = s_ra[k][3:0];
      iss_rb[k*4 +: 4]      = s_rb[k][3:0];
      left_in[k*DW +: DW]   = s_l[k];
      right_in[k*DW +: DW]  = s_r[k];
    end
    cfg_load = s_cl;
    cfg_word = s_cw;
    if (m_req && m_wr) mem[m_addr[5:0]] = m_wdata;
    if (m_req && !m_wr) mem_rdata = mem[m_addr[5:0]];
    else mem_rdata = $urandom;
  endtask

  task automatic model_step();
    logic [DW-1:0] opa[N], opb[N], o_prev[N], lres, y;
    bit ok;
    for (int k = 0; k < N; k++) begin
      opa[k] = pick(k, int'(m_cfg[(2*k)*SW +: SW]),   m_rf[k][s_ra[k]]);
      opb[k] = pick(k, int'(m_cfg[(2*k+1)*SW +: SW]), m_rf[k][s_rb[k]]);
      o_prev[k] = m_out[k];
    end
    for (int k = 0; k < N; k++) begin
      lres = lp_ld[k] ? mem_rdata : lp_prod[k];
      y = ref_alu(s_op[k], opa[k], opb[k], ok);
      if (lp_v[k]) begin
        m_out[k] = lres; m_val[k] = 1;
        if (lp_we[k]) m_rf[k][lp_rd[k]] = lres;
      end else if (s_v[k] && ok) begin
        m_out[k] = y; m_val[k] = 1;
        if (s_we[k]) m_rf[k][s_rd[k]] = y;
      end else m_val[k] = 0;
      m_ill[k] = s_v[k] && ((s_op[k] == 10 && k != 2) || ((s_op[k] == 11 || s_op[k] == 12) && k != 1));
      lp_v[k]  = s_v[k] && ((s_op[k] == 10 && k == 2) || (s_op[k] == 11 && k == 1));
      lp_ld[k] = (s_op[k] == 11);
      lp_we[k] = s_we[k];
      lp_rd[k] = s_rd[k];
      lp_prod[k] = opa[k] * opb[k];
    end
    m_req   = s_v[1] && (s_op[1] == 11 || s_op[1] == 12);
    m_wr    = s_v[1] && (s_op[1] == 12);
    m_addr  = opa[1];
    m_wdata = opb[1];
    if (s_cl) m_cfg = s_cw;
    if (o_prev[0] === 'x) m_out[0] = m_out[0];
  endtask

  task automatic compare();
    for (int k = 0; k < N; k++) begin
      chk(res_out[k*DW +: DW] === m_out[k], $sformatf("res_out[%0d]", k), res_out[k*DW +: DW], m_out[k]);
      chk(res_valid[k] === m_val[k], $sformatf("res_valid[%0d]", k), 32'(res_valid[k]), 32'(m_val[k]));
      chk(illegal_op[k] === m_ill[k], $sformatf("illegal_op[%0d]", k), 32'(illegal_op[k]), 32'(m_ill[k]));
    end
    chk(mem_req === m_req, "mem_req", 32'(mem_req), 32'(m_req));
    if (m_req) begin
      chk(mem_wr === m_wr, "mem_wr", 32'(mem_wr), 32'(m_wr));
      chk(mem_addr === m_addr, "mem_addr", mem_addr, m_addr);
      if (m_wr) chk(mem_wdata === m_wdata, "mem_wdata", mem_wdata, m_wdata);
    end
  endtask

  task automatic tick();
    apply();
    model_step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic load_cfg(logic [CW-1:0] w);
    s_cl = 1; s_cw = w;
    tick();
  endtask

  task automatic issue(int k, int op, int rd, int ra, int rb, bit we);
    s_v[k] = 1; s_op[k] = op; s_rd[k] = rd; s_ra[k] = ra; s_rb[k] = rb; s_we[k] = we;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired in %s", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    for (int k = 0; k < N; k++) begin
      m_out[k] = '0; m_val[k] = 0; m_ill[k] = 0;
      lp_v[k] = 0; lp_ld[k] = 0; lp_we[k] = 0; lp_rd[k] = 0; lp_prod[k] = '0;
    end
    m_req = 0; m_wr = 0; m_addr = '0; m_wdata = '0; m_cfg = '0;
    rst = 1'b1;
    idle();
    apply();
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    compare();
    rst = 1'b0;
    @(negedge clk);
    compare();

    // R4 / R10: fill every register from the left neighbour
    tag = "R4";
    load_cfg(cfg_all(5, 7));
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < N; k++) issue(k, 9, r, 0, 0, 1);
      tick();
    end
    load_cfg(cfg_all(6, 7));
    for (int k = 0; k < N; k++) issue(k, 9, 3, 0, 0, 0);
    tag = "R10";
    tick();
    load_cfg(cfg_all(0, 0));
    for (int k = 0; k < N; k++) issue(k, 9, 0, 3, 0, 0);
    tick();

    // R2: each ALU opcode from register operands
    tag = "R2";
    for (int op = 1; op <= 9; op++) begin
      for (int k = 0; k < N; k++) issue(k, op, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom));
      tick();
    end

    // R3: forwarding through the group crossbar
    tag = "R3";
    for (int i = 0; i < 20; i++) begin
      s_cl = 1;
      for (int k = 0; k < N; k++) begin
        s_cw[(2*k)*SW +: SW]   = SW'($urandom_range(1, 4));
        s_cw[(2*k+1)*SW +: SW] = (i % 3 == 0) ? 3'd7 : SW'($urandom_range(0, 4));
        issue(k, $urandom_range(1, 9), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom));
      end
      tick();
    end

    // R6: back-to-back multiplies on unit 2
    tag = "R6";
    load_cfg(cfg_all(0, 0));
    for (int i = 0; i < 6; i++) begin
      issue(2, 10, i, $urandom_range(0, 15), $urandom_range(0, 15), 1);
      tick();
    end
    tick(); tick();

    // R8: unsupported ops on the wrong units
    tag = "R8";
    issue(0, 10, 1, 2, 3, 1); issue(3, 11, 1, 2, 3, 1); issue(2, 12, 1, 2, 3, 1); issue(1, 10, 1, 2, 3, 1);
    tick();
    issue(0, 12, 1, 2, 3, 1); issue(2, 11, 4, 2, 3, 1);
    tick(); tick();

    // R7: stores then loads on unit 1
    tag = "R7";
    for (int i = 0; i < 4; i++) begin
      issue(1, 12, 0, i, i + 4, 0);
      tick();
    end
    for (int i = 0; i < 4; i++) begin
      issue(1, 11, 8 + i, i, 0, 1);
      tick();
    end
    tick(); tick();

    // R9: long op completing against a new ALU op on the same unit
    tag = "R9";
    issue(2, 10, 3, 1, 2, 1); tick();
    issue(2, 1, 6, 4, 5, 1); tick();
    tick();
    issue(2, 9, 0, 6, 0, 0); tick();
    issue(1, 11, 5, 2, 0, 1); tick();
    issue(1, 2, 7, 3, 4, 1); tick();
    tick();
    issue(1, 9, 0, 7, 0, 0); tick();

    // R11: reserved opcodes leave no trace
    tag = "R11";
    for (int op = 13; op <= 16; op++) begin
      for (int k = 0; k < N; k++) issue(k, op % 16, 9, 1, 2, 1);
      tick();
    end
    for (int k = 0; k < N; k++) issue(k, 9, 0, 9, 0, 0);
    tick();

    // R5: configuration held while the strobe is low
    tag = "R5";
    load_cfg(cfg_all(5, 6));
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < N; k++) issue(k, 1, 0, 0, 0, 0);
      s_cw = CW'($urandom);
      tick();
    end
    s_cl = 1; s_cw = cfg_all(6, 5);
    for (int k = 0; k < N; k++) issue(k, 2, 0, 0, 0, 0);
    tick();
    for (int k = 0; k < N; k++) issue(k, 2, 0, 0, 0, 0);
    tick();

    // mixed traffic: all opcodes, sources and reconfigurations
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin s_cl = 1; s_cw = CW'($urandom); end
      for (int k = 0; k < N; k++) begin
        if ($urandom_range(0, 3) != 0)
          issue(k, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom));
      end
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule